// File: doc/BRIEF.md
# Snooping Invalidate Cache Controller

This block is the coherence controller of one write-back data cache that shares a snooping bus with other caches. It keeps a small direct-mapped array in which every line carries a tag, one data word and one of three states: Invalid, Shared (a clean copy that may be read) or Exclusive (the only copy, writable and dirty). Processor reads and writes arrive over a valid/ready handshake. Hits complete in the cycle they are presented. Misses are resolved on the bus after the controller has won arbitration.

On the bus side the controller raises a request and waits for a grant. It then drives one transaction and holds it until the memory side signals completion. A transaction is a read miss, a write miss or a write-back, and it carries a block address and one data word. The controller also watches the misses that other caches place on the bus. A snooped miss that hits a dirty local line forces that line to be written back before it is downgraded or dropped. A write to a Shared line is not done in place: it goes out as a full write miss, which removes every other copy.

The processor must hold its request stable until it sees ready. After a miss has been filled, the held request is accepted as an ordinary hit.

Top module: `snoop_inv_cache`

## Requirements
- R1: After reset every line is Invalid, `bus_req` is low, `bus_cmd_o` is idle (00), and `cpu_ready` is high while no request is presented. The first access to any address therefore misses.
- R2: A read whose tag matches a Shared or Exclusive line has `cpu_ready` high in the same cycle, returns the line's data on `cpu_rdata`, and places nothing on the bus.
- R3: A read that misses keeps `cpu_ready` low and issues one read miss (code 01) carrying the requested address. The line is then filled as Shared with the word returned on `bus_rdata`, and the held read completes with that word.
- R4: A write to a line that is Invalid, Shared or holds another tag issues one write miss (code 10) carrying the requested address. After the fill, the held write completes and leaves the line Exclusive with the written word. A write to an Exclusive line with a matching tag completes in the cycle it is presented and places nothing on the bus.
- R5: No transaction is driven before `bus_gnt` has been seen. A driven command, address and data stay stable until `bus_done`, and no line changes before that completion.
- R6: A miss to an index whose line is Exclusive under another tag first writes back the old block (code 11, old address, old data). It then issues the miss for the new address.
- R7: A snooped read miss (01 on `snoop_cmd`) whose address matches an Exclusive line causes a write-back of that line's address and data. The line becomes Shared and keeps its data, so a later local read hits.
- R8: A snooped write miss (10) whose address matches an Exclusive line causes a write-back of its data, and the line then becomes Invalid.
- R9: A snooped write miss that matches a Shared line makes it Invalid one cycle later with no bus traffic. A snooped read miss to a Shared line leaves it Shared. Snooped write-backs (11), and snoops whose tag differs from the line at that index, change nothing. In any cycle where a snoop matches a valid line, `cpu_ready` is low.
- R10: While a local miss waits for a grant, a snooped miss that needs a write-back is served first. Its write-back is the next transaction on the bus, ahead of the pending miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits select the line, the rest form the tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted this cycle (low while a miss or snoop is handled) |
| cpu_rdata | output | DATA_W | Read data, valid when ready and valid are both high |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_cmd_o | output | 2 | Transaction: 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Block address of the transaction |
| bus_data_o | output | DATA_W | Data word of the transaction (write-back data) |
| bus_done | input | 1 | One-cycle completion of the driven transaction |
| bus_rdata | input | DATA_W | Memory data returned with completion of a miss |
| snoop_cmd | input | 2 | Transaction of another cache seen on the bus, same codes |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
A hit answers combinationally, so the bench checks ready and read data about 1 ns after it has driven the request at a falling edge. A miss is slower. The grant register follows the request one edge later. The command appears on the edge after the grant is seen, the memory model completes it one edge after that, and the line is filled on the completion edge. The held access is then accepted on the next cycle. The bench does not predict that exact cycle. It polls ready at each falling edge and compares the bus transactions, which the memory model records on the completion edge, only after ready has returned or `bus_req` has dropped. A snooped invalidation of a Shared line is due one edge after the snoop, so the bench lets at least one more cycle pass before the read that must miss.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRMISS = 2'd2,
        BUS_WB     = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FSM_IDLE    = 3'd0,
        FSM_WAIT    = 3'd1,
        FSM_ISSUE   = 3'd2,
        FSM_SWAIT   = 3'd3,
        FSM_SISSUE  = 3'd4
    } ctl_state_e;

    function automatic logic is_miss(bus_cmd_e c);
        return (c == BUS_RDMISS) || (c == BUS_WRMISS);
    endfunction

endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store
    import cc_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output line_state_e       states_o [LINES]
);

    line_state_e       st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= LN_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (we && (wr_idx == IDX_W'(g))) begin
                st_q[g]   <= wr_state;
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
        assign states_o[g] = st_q[g];
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

endmodule

// File: rtl/cc_snoop_filter.sv
module cc_snoop_filter
    import cc_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_state_e      ln_state,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             hit,
    output logic             need_wb,
    output line_state_e      next_state
);

    always_comb begin
        hit        = is_miss(snp_cmd) && (ln_state != LN_INV) && (snp_tag == ln_tag);
        need_wb    = hit && (ln_state == LN_EXC);
        next_state = (snp_cmd == BUS_RDMISS) ? LN_SHR : LN_INV;
    end

endmodule

// File: rtl/snoop_inv_cache.sv
module snoop_inv_cache
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_e        fsm_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_write_q;
    logic              pend_q;
    bus_cmd_e          op_q;
    logic [ADDR_W-1:0] iss_addr_q;
    logic [DATA_W-1:0] iss_data_q;
    logic [IDX_W-1:0]  snp_idx_q;
    line_state_e       snp_next_q;

    logic [IDX_W-1:0]  cpu_idx, req_idx, snp_idx, a_idx, b_idx;
    logic [TAG_W-1:0]  cpu_tag, req_tag, snp_tag;
    line_state_e       a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    line_state_e       ln_states [LINES];

    logic              we;
    logic [IDX_W-1:0]  wr_idx;
    line_state_e       wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    logic              snp_hit_raw, snp_wb, snp_act;
    line_state_e       snp_next;
    logic              hit_rd, hit_wr, cpu_hit;
    bus_cmd_e          plan_op;
    logic [ADDR_W-1:0] plan_addr;
    logic [DATA_W-1:0] plan_data;
    logic              snp_phase, watch_snoop;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = req_addr_q[IDX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
    assign snp_idx = snoop_addr[IDX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

    assign snp_phase   = (fsm_q == FSM_SWAIT) || (fsm_q == FSM_SISSUE);
    assign watch_snoop = (fsm_q == FSM_IDLE) || (fsm_q == FSM_WAIT);
    assign a_idx       = (fsm_q == FSM_IDLE) ? cpu_idx : req_idx;
    assign b_idx       = snp_phase ? snp_idx_q : snp_idx;

    cc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .a_idx    (a_idx),
        .a_state  (a_state),
        .a_tag    (a_tag),
        .a_data   (a_data),
        .b_idx    (b_idx),
        .b_state  (b_state),
        .b_tag    (b_tag),
        .b_data   (b_data),
        .we       (we),
        .wr_idx   (wr_idx),
        .wr_state (wr_state),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .states_o (ln_states)
    );

    cc_snoop_filter #(.TAG_W(TAG_W)) u_filter (
        .snp_cmd    (bus_cmd_e'(snoop_cmd)),
        .snp_tag    (snp_tag),
        .ln_state   (b_state),
        .ln_tag     (b_tag),
        .hit        (snp_hit_raw),
        .need_wb    (snp_wb),
        .next_state (snp_next)
    );

    assign snp_act = watch_snoop && snp_hit_raw;

    // processor-side hit detection (port A follows cpu_addr while idle)
    always_comb begin
        hit_rd  = (a_state != LN_INV) && (a_tag == cpu_tag);
        hit_wr  = (a_state == LN_EXC) && (a_tag == cpu_tag);
        cpu_hit = cpu_write ? hit_wr : hit_rd;
    end

    assign cpu_ready = (fsm_q == FSM_IDLE) && !snp_act && (!cpu_valid || cpu_hit);
    assign cpu_rdata = a_data;

    // next transaction for the pending request, re-derived every wait cycle
    always_comb begin
        if ((a_state == LN_EXC) && (a_tag != req_tag)) begin
            plan_op   = BUS_WB;
            plan_addr = {a_tag, req_idx};
            plan_data = a_data;
        end else begin
            plan_op   = req_write_q ? BUS_WRMISS : BUS_RDMISS;
            plan_addr = req_addr_q;
            plan_data = '0;
        end
    end

    // single line write port: snoop updates, write hits and bus fills
    always_comb begin
        we       = 1'b0;
        wr_idx   = a_idx;
        wr_state = a_state;
        wr_tag   = a_tag;
        wr_data  = a_data;
        unique case (fsm_q)
            FSM_IDLE, FSM_WAIT: begin
                if (snp_act && !snp_wb) begin
                    we       = 1'b1;
                    wr_idx   = snp_idx;
                    wr_state = snp_next;
                    wr_tag   = b_tag;
                    wr_data  = b_data;
                end else if ((fsm_q == FSM_IDLE) && !snp_act && cpu_valid && cpu_write && hit_wr) begin
                    we       = 1'b1;
                    wr_idx   = cpu_idx;
                    wr_state = LN_EXC;
                    wr_tag   = cpu_tag;
                    wr_data  = cpu_wdata;
                end
            end
            FSM_ISSUE: begin
                if (bus_done) begin
                    we     = 1'b1;
                    wr_idx = req_idx;
                    if (op_q == BUS_WB) begin
                        wr_state = LN_INV;
                    end else begin
                        wr_state = (op_q == BUS_WRMISS) ? LN_EXC : LN_SHR;
                        wr_tag   = req_tag;
                        wr_data  = bus_rdata;
                    end
                end
            end
            FSM_SISSUE: begin
                if (bus_done) begin
                    we       = 1'b1;
                    wr_idx   = snp_idx_q;
                    wr_state = snp_next_q;
                    wr_tag   = b_tag;
                    wr_data  = b_data;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q       <= FSM_IDLE;
            req_addr_q  <= '0;
            req_write_q <= 1'b0;
            pend_q      <= 1'b0;
            op_q        <= BUS_IDLE;
            iss_addr_q  <= '0;
            iss_data_q  <= '0;
            snp_idx_q   <= '0;
            snp_next_q  <= LN_INV;
        end else begin
            unique case (fsm_q)
                FSM_IDLE, FSM_WAIT: begin
                    if (snp_act) begin
                        if (snp_wb) begin
                            fsm_q      <= FSM_SWAIT;
                            snp_idx_q  <= snp_idx;
                            snp_next_q <= snp_next;
                        end
                    end else if (fsm_q == FSM_IDLE) begin
                        if (cpu_valid && !cpu_hit) begin
                            fsm_q       <= FSM_WAIT;
                            req_addr_q  <= cpu_addr;
                            req_write_q <= cpu_write;
                            pend_q      <= 1'b1;
                        end
                    end else if (bus_gnt) begin
                        fsm_q      <= FSM_ISSUE;
                        op_q       <= plan_op;
                        iss_addr_q <= plan_addr;
                        iss_data_q <= plan_data;
                    end
                end
                FSM_ISSUE: begin
                    if (bus_done) begin
                        if (op_q == BUS_WB) begin
                            fsm_q <= FSM_WAIT;
                        end else begin
                            fsm_q  <= FSM_IDLE;
                            pend_q <= 1'b0;
                        end
                    end
                end
                FSM_SWAIT: begin
                    if (bus_gnt) begin
                        fsm_q      <= FSM_SISSUE;
                        op_q       <= BUS_WB;
                        iss_addr_q <= {b_tag, snp_idx_q};
                        iss_data_q <= b_data;
                    end
                end
                FSM_SISSUE: begin
                    if (bus_done) begin
                        fsm_q <= pend_q ? FSM_WAIT : FSM_IDLE;
                    end
                end
                default: fsm_q <= FSM_IDLE;
            endcase
        end
    end

    assign bus_req    = (fsm_q != FSM_IDLE);
    assign bus_cmd_o  = ((fsm_q == FSM_ISSUE) || (fsm_q == FSM_SISSUE)) ? op_q : BUS_IDLE;
    assign bus_addr_o = iss_addr_q;
    assign bus_data_o = iss_data_q;

    // R5: a transaction starts only after a grant was observed
    assert_issue_after_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cmd_o != BUS_IDLE) |-> $past(bus_gnt));

    // R5: command and address hold until completion
    assert_cmd_held_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_o != BUS_IDLE && !bus_done) |=>
            (bus_cmd_o == $past(bus_cmd_o)) && (bus_addr_o == $past(bus_addr_o)));

    // R4: an accepted write leaves its line Exclusive
    assert_write_excl_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready && cpu_write) |=> (ln_states[$past(cpu_idx)] == LN_EXC));

    // R9: snooped write miss to a Shared line drops it without bus traffic
    assert_snoop_shared_inv_R9: assert property (@(posedge clk) disable iff (rst)
        (snp_act && !snp_wb && bus_cmd_e'(snoop_cmd) == BUS_WRMISS) |=>
            (ln_states[$past(snp_idx)] == LN_INV) && (bus_cmd_o == BUS_IDLE));

    // R8: dirty data never leaves a line except through a completed write-back
    for (genvar i = 0; i < LINES; i++) begin : g_chk
        assert_excl_exit_wb_R8: assert property (@(posedge clk) disable iff (rst)
            (ln_states[i] == LN_EXC) |=>
                (ln_states[i] == LN_EXC) || ($past(bus_done) && $past(bus_cmd_o) == BUS_WB));
    end

endmodule

// File: tb/snoop_inv_cache_test.sv
`timescale 1ns/1ps
module snoop_inv_cache_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_valid, cpu_write;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req, bus_gnt;
    logic [1:0]  bus_cmd_o;
    logic [7:0]  bus_addr_o;
    logic [15:0] bus_data_o;
    logic        bus_done;
    logic [15:0] bus_rdata;
    logic [1:0]  snoop_cmd;
    logic [7:0]  snoop_addr;

    logic        hold_gnt;
    logic [15:0] mem [256];
    logic [1:0]  log_cmd  [32];
    logic [7:0]  log_addr [32];
    logic [15:0] log_data [32];
    int          log_n;
    int          n_chk, n_fail;
    bit          finished;

    always #10 clk = ~clk;

    snoop_inv_cache uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr)
    );

    function automatic logic [15:0] init_val(input logic [7:0] a);
        return 16'h5A00 + {8'h00, a} * 16'd3;
    endfunction

    // arbiter, memory responder and transaction log
    always @(posedge clk) begin
        if (rst) begin
            bus_gnt  <= 1'b0;
            bus_done <= 1'b0;
            log_n    <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
        end else begin
            bus_gnt   <= bus_req && !hold_gnt;
            bus_done  <= (bus_cmd_o != 2'd0) && !bus_done;
            bus_rdata <= mem[bus_addr_o];
            if (bus_cmd_o == 2'd3 && !bus_done) mem[bus_addr_o] <= bus_data_o;
            if (bus_done && log_n < 32) begin
                log_cmd[log_n]  <= bus_cmd_o;
                log_addr[log_n] <= bus_addr_o;
                log_data[log_n] <= bus_data_o;
                log_n           <= log_n + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic wr, input logic [7:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output int cyc);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a);
        @(negedge clk);
        snoop_cmd = c; snoop_addr = a;
        @(negedge clk);
        snoop_cmd = 2'd0;
        #1;
        for (int k = 0; k < 50 && bus_req; k++) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] rd; int cyc, n0;
        @(negedge clk); #1;
        chk("R1 ready idle", cpu_ready, 1);
        chk("R1 no req", bus_req, 0);
        chk("R1 bus idle", bus_cmd_o, 0);
        n0 = log_n;
        cpu_op(0, 8'h11, 0, rd, cyc);
        chk("R3 read miss count", log_n - n0, 1);
        chk("R3 read miss cmd", log_cmd[n0], 1);
        chk("R3 read miss addr", log_addr[n0], 8'h11);
        chk("R3 fill data", rd, init_val(8'h11));
        chk("R3 ready held low", cyc > 2, 1);
    endtask

    task automatic t_hits;
        logic [15:0] rd; int cyc, n0;
        n0 = log_n;
        cpu_op(0, 8'h11, 0, rd, cyc);
        chk("R2 shared hit cycles", cyc, 0);
        chk("R2 shared hit data", rd, init_val(8'h11));
        chk("R2 no bus", log_n - n0, 0);
        cpu_op(1, 8'h11, 16'hBEEF, rd, cyc);
        chk("R4 write on shared is miss", log_n - n0, 1);
        chk("R4 write miss cmd", log_cmd[n0], 2);
        chk("R4 write miss addr", log_addr[n0], 8'h11);
        n0 = log_n;
        cpu_op(0, 8'h11, 0, rd, cyc);
        chk("R2 excl hit data", rd, 16'hBEEF);
        cpu_op(1, 8'h11, 16'hCAFE, rd, cyc);
        chk("R4 excl write hit cycles", cyc, 0);
        chk("R4 excl write no bus", log_n - n0, 0);
    endtask

    task automatic t_evict;
        logic [15:0] rd; int cyc, n0;
        n0 = log_n;
        cpu_op(0, 8'h15, 0, rd, cyc);
        chk("R6 two transactions", log_n - n0, 2);
        chk("R6 wb first", log_cmd[n0], 3);
        chk("R6 wb addr", log_addr[n0], 8'h11);
        chk("R6 wb data", log_data[n0], 16'hCAFE);
        chk("R6 then read miss", log_cmd[n0+1], 1);
        chk("R6 read miss addr", log_addr[n0+1], 8'h15);
        chk("R6 new data", rd, init_val(8'h15));
    endtask

    task automatic t_snoop_read;
        logic [15:0] rd; int cyc, n0;
        cpu_op(1, 8'h22, 16'h1234, rd, cyc);
        n0 = log_n;
        snoop(2'd1, 8'h22);
        chk("R7 snoop wb count", log_n - n0, 1);
        chk("R7 snoop wb cmd", log_cmd[n0], 3);
        chk("R7 snoop wb addr", log_addr[n0], 8'h22);
        chk("R7 snoop wb data", log_data[n0], 16'h1234);
        n0 = log_n;
        cpu_op(0, 8'h22, 0, rd, cyc);
        chk("R7 shared keeps data", rd, 16'h1234);
        chk("R7 read hits", log_n - n0, 0);
    endtask

    task automatic t_snoop_write;
        logic [15:0] rd; int cyc, n0;
        n0 = log_n;
        snoop(2'd2, 8'h22);
        chk("R9 shared inval no bus", log_n - n0, 0);
        cpu_op(0, 8'h22, 0, rd, cyc);
        chk("R9 read misses after inval", log_n - n0, 1);
        chk("R9 data from memory", rd, 16'h1234);
        cpu_op(1, 8'h33, 16'h7777, rd, cyc);
        n0 = log_n;
        snoop(2'd2, 8'h33);
        chk("R8 snoop wb cmd", log_cmd[n0], 3);
        chk("R8 snoop wb data", log_data[n0], 16'h7777);
        n0 = log_n;
        cpu_op(0, 8'h33, 0, rd, cyc);
        chk("R8 line invalid", log_n - n0, 1);
        chk("R8 memory data", rd, 16'h7777);
    endtask

    task automatic t_snoop_ignored;
        logic [15:0] rd; int cyc, n0;
        n0 = log_n;
        snoop(2'd2, 8'h05);
        snoop(2'd3, 8'h15);
        snoop(2'd1, 8'h15);
        cpu_op(0, 8'h15, 0, rd, cyc);
        chk("R9 ignored snoops keep line", cyc, 0);
        chk("R9 ignored snoops no bus", log_n - n0, 0);
        chk("R9 data kept", rd, init_val(8'h15));
    endtask

    task automatic t_priority;
        logic [15:0] rd; int cyc, n0;
        cpu_op(1, 8'h03, 16'h0303, rd, cyc);
        hold_gnt = 1'b1;
        repeat (3) @(negedge clk);
        n0 = log_n;
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h10;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 ready low while waiting", cpu_ready, 0);
        chk("R5 no command before grant", bus_cmd_o, 0);
        snoop_cmd = 2'd1; snoop_addr = 8'h03;
        @(negedge clk);
        snoop_cmd = 2'd0;
        hold_gnt = 1'b0;
        #1;
        cyc = 0;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_valid = 1'b0;
        chk("R10 two transactions", log_n - n0, 2);
        chk("R10 snoop wb first", log_cmd[n0], 3);
        chk("R10 snoop wb addr", log_addr[n0], 8'h03);
        chk("R10 then pending miss", log_cmd[n0+1], 1);
        chk("R10 pending miss addr", log_addr[n0+1], 8'h10);
        chk("R10 pending data", rd, init_val(8'h10));
    endtask

    initial begin
        n_chk = 0; n_fail = 0; finished = 0;
        rst = 1'b1; hold_gnt = 1'b0;
        cpu_valid = 0; cpu_write = 0; cpu_addr = 0; cpu_wdata = 0;
        snoop_cmd = 0; snoop_addr = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_hits;
        t_evict;
        t_snoop_read;
        t_snoop_write;
        t_snoop_ignored;
        t_priority;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule